// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Write Controller

This block is a clocked master for a dual-channel 8-bit converter whose digital port is a set of level-sensitive transparent latches behind one shared data bus. A requester hands it a write through a valid/ready handshake. The write carries a channel bit and a data word. The controller then plays out a write cycle in the style of a static RAM on the port. It drives an active-low chip select, an active-low write strobe, a channel-select line and the data bus. The setup, strobe-width and hold intervals are each set in clock cycles by parameters.

The target latch follows the bus while chip select and write are both low, and it freezes on whichever strobe rises first. For that reason the controller settles the channel select and the data before the write strobe falls. It keeps them unchanged through the strobe and for a hold interval after it. A paired request updates channel A and then channel B in two back-to-back write cycles. Chip select stays low between the two cycles.

Top module: `dac_port_writer`

## Requirements
- R1: While reset is asserted and after its release, chip select and write are high (inactive) and ready is high.
- R2: A request is taken only on a clock edge where valid and ready are both high. Ready is low from the cycle after acceptance until the hold interval of the last write has ended, and valid is ignored while ready is low.
- R3: The write strobe is low only while chip select is low.
- R4: Channel select and data do not change while the write strobe is low, and they do not change in the cycle in which it rises.
- R5: Each write strobe stays low for exactly P = max(WR_PULSE,1) cycles.
- R6: After acceptance, chip select, channel select and data are driven for L = max(1, max(CS_SETUP,SEL_SETUP,DATA_SETUP) − P) cycles before the write strobe falls, so each of them is valid at least its own setup count before the strobe rises.
- R7: After the write strobe rises, chip select, channel select and data are held for H = max(HOLD,1) cycles before chip select rises or the next word is driven.
- R8: Channel select low (0) addresses channel A and high (1) addresses channel B. After a single write, the addressed channel's latch holds the data and the other channel is unchanged.
- R9: A paired request writes its first data word to channel A and then its second data word to channel B, and the channel bit is ignored. One cycle with chip select low and the strobe high separates the two write cycles.
- R10: Ready returns high exactly L+P+H cycles after acceptance for a single write, and 2·(L+P+H)+1 cycles after acceptance for a paired write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_chan | input | 1 | Target channel for a single write (0 = A, 1 = B) |
| req_pair | input | 1 | Write both channels, A then B |
| req_data | input | DW | Data for a single write, or the channel A word of a pair |
| req_data_b | input | DW | Channel B word of a paired write |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_sel | output | 1 | Channel select (0 = A, 1 = B) |
| dac_db | output | DW | Shared data bus |

## Verification
The bench builds the block with CS_SETUP=3, SEL_SETUP=1, DATA_SETUP=5, WR_PULSE=2 and HOLD=0. With these values the data setup exceeds the strobe width, so the lead interval comes out at 3 cycles rather than the floor of 1. The zero hold is rounded up to one cycle. The bench predicts every cycle of each write from its own arithmetic and compares it. A behavioural transparent-latch model of both channels checks against a scoreboard that the data landed where the channel encoding says. It also counts any change of select or data while both strobes are low. Requests raised during a busy interval show at the ports that they are ignored.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_NEXT   = 3'd4
  } wr_state_e;

  // A zero interval is never allowed on the port: round up to one cycle.
  function automatic int unsigned at_least_one(input int unsigned x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles between driving select/data and the strobe falling. The strobe
  // width itself counts toward every setup measured to the rising edge.
  function automatic int unsigned lead_len(input int unsigned cs_su, input int unsigned sel_su,
                                           input int unsigned dat_su, input int unsigned pulse);
    int unsigned m;
    int unsigned p;
    m = max3(cs_su, sel_su, dat_su);
    p = at_least_one(pulse);
    return (m > p) ? (m - p) : 1;
  endfunction

endpackage

// File: rtl/dacwr_seq.sv
module dacwr_seq
  import dacwr_pkg::*;
#(
  parameter int unsigned LEAD  = 1,
  parameter int unsigned PULSE = 1,
  parameter int unsigned HOLDC = 1,
  localparam int unsigned MAXD = max3(LEAD, PULSE, HOLDC),
  localparam int unsigned CW   = $clog2(MAXD + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      second_pending,
  output wr_state_e state,
  output logic      accept_evt,
  output logic      swap_evt
);

  localparam logic [CW-1:0] LEAD_M1  = CW'(LEAD - 1);
  localparam logic [CW-1:0] PULSE_M1 = CW'(PULSE - 1);
  localparam logic [CW-1:0] HOLD_M1  = CW'(HOLDC - 1);

  wr_state_e      nxt;
  logic [CW-1:0]  cnt;
  logic           cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign accept_evt = (state == ST_IDLE) && start;
  assign swap_evt   = (state == ST_HOLD) && cnt_zero && second_pending;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start)    nxt = ST_SETUP;
      ST_SETUP:  if (cnt_zero) nxt = ST_STROBE;
      ST_STROBE: if (cnt_zero) nxt = ST_HOLD;
      ST_HOLD:   if (cnt_zero) nxt = second_pending ? ST_NEXT : ST_IDLE;
      ST_NEXT:   nxt = ST_SETUP;
      default:   nxt = ST_IDLE;
    endcase
  end

  function automatic logic [CW-1:0] entry_count(input wr_state_e s);
    case (s)
      ST_SETUP:  return LEAD_M1;
      ST_STROBE: return PULSE_M1;
      ST_HOLD:   return HOLD_M1;
      default:   return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)   cnt <= entry_count(nxt);
      else if (!cnt_zero) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/dacwr_word_reg.sv
module dacwr_word_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          swap,
  input  logic          in_chan,
  input  logic          in_pair,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] in_data_b,
  output logic          sel,
  output logic [DW-1:0] db,
  output logic          pending
);

  logic [DW-1:0] spare_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= 1'b0;
      db      <= '0;
      pending <= 1'b0;
      spare_q <= '0;
    end else if (load) begin
      sel     <= in_pair ? 1'b0 : in_chan;
      db      <= in_data;
      pending <= in_pair;
      spare_q <= in_data_b;
    end else if (swap) begin
      sel     <= 1'b1;
      db      <= spare_q;
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/dacwr_strobe_dec.sv
module dacwr_strobe_dec
  import dacwr_pkg::*;
(
  input  wr_state_e state,
  output logic      cs_n,
  output logic      wr_n,
  output logic      ready
);

  // Decoded straight from the state flops: one-hot-like compares, no
  // combinational input reaches the port strobes.
  assign ready = (state == ST_IDLE);
  assign cs_n  = (state == ST_IDLE);
  assign wr_n  = (state != ST_STROBE);

endmodule

// File: rtl/dac_port_writer.sv
module dac_port_writer
  import dacwr_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned CS_SETUP   = 2,
  parameter int unsigned SEL_SETUP  = 2,
  parameter int unsigned DATA_SETUP = 2,
  parameter int unsigned WR_PULSE   = 2,
  parameter int unsigned HOLD       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_chan,
  input  logic          req_pair,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_data_b,
  output logic          dac_cs_n,
  output logic          dac_wr_n,
  output logic          dac_sel,
  output logic [DW-1:0] dac_db
);

  localparam int unsigned PULSE_C = at_least_one(WR_PULSE);
  localparam int unsigned HOLD_C  = at_least_one(HOLD);
  localparam int unsigned LEAD_C  = lead_len(CS_SETUP, SEL_SETUP, DATA_SETUP, WR_PULSE);

  wr_state_e state;
  logic      accept_evt;
  logic      swap_evt;
  logic      second_pending;

  dacwr_seq #(
    .LEAD (LEAD_C),
    .PULSE(PULSE_C),
    .HOLDC(HOLD_C)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (req_valid),
    .second_pending(second_pending),
    .state         (state),
    .accept_evt    (accept_evt),
    .swap_evt      (swap_evt)
  );

  dacwr_word_reg #(.DW(DW)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .swap     (swap_evt),
    .in_chan  (req_chan),
    .in_pair  (req_pair),
    .in_data  (req_data),
    .in_data_b(req_data_b),
    .sel      (dac_sel),
    .db       (dac_db),
    .pending  (second_pending)
  );

  dacwr_strobe_dec u_dec (
    .state(state),
    .cs_n (dac_cs_n),
    .wr_n (dac_wr_n),
    .ready(req_ready)
  );

endmodule

// File: rtl/dacwr_checker.sv
module dacwr_checker #(
  parameter int unsigned DW        = 8,
  parameter int unsigned PULSE_CYC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          dac_cs_n,
  input logic          dac_wr_n,
  input logic          dac_sel,
  input logic [DW-1:0] dac_db
);

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (dac_wr_n) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (dac_cs_n && dac_wr_n));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !dac_cs_n);

  assert_strobe_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !dac_cs_n);

  assert_stable_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_db) && $stable(dac_sel)));

  assert_stable_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_db) && $stable(dac_sel)));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (low_run == 16'(PULSE_CYC)));

  assert_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> !dac_cs_n);

endmodule

bind dac_port_writer dacwr_checker #(
  .DW       (DW),
  .PULSE_CYC(dacwr_pkg::at_least_one(WR_PULSE))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .dac_cs_n (dac_cs_n),
  .dac_wr_n (dac_wr_n),
  .dac_sel  (dac_sel),
  .dac_db   (dac_db)
);

// File: tb/dac_port_writer_test.sv
module dac_port_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int T_CS = 3, T_SEL = 1, T_DAT = 5, T_PW = 2, T_HOLD = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_chan = 1'b0;
  logic req_pair = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic [DW-1:0] req_data_b = '0;
  logic req_ready, dac_cs_n, dac_wr_n, dac_sel;
  logic [DW-1:0] dac_db;

  int checks = 0;
  int fails = 0;
  int violations = 0;
  logic [DW-1:0] lat_a = '0, lat_b = '0;
  logic [DW-1:0] sb_a = '0, sb_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_port_writer #(
    .DW(DW), .CS_SETUP(T_CS), .SEL_SETUP(T_SEL), .DATA_SETUP(T_DAT),
    .WR_PULSE(T_PW), .HOLD(T_HOLD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_pair(req_pair), .req_data(req_data),
    .req_data_b(req_data_b), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
    .dac_sel(dac_sel), .dac_db(dac_db)
  );

  // Behavioural transparent latches of the converter port.
  always @(dac_cs_n or dac_wr_n or dac_sel or dac_db) begin
    if (!dac_cs_n && !dac_wr_n) begin
      if (dac_sel) lat_b = dac_db;
      else         lat_a = dac_db;
    end
  end

  // Any select or data movement while the latch is open is a protocol error.
  always @(dac_sel or dac_db) begin
    if (rst_n && !dac_cs_n && !dac_wr_n) violations++;
  end

  function automatic int exp_pulse();
    return (T_PW < 1) ? 1 : T_PW;
  endfunction
  function automatic int exp_hold();
    return (T_HOLD < 1) ? 1 : T_HOLD;
  endfunction
  function automatic int exp_lead();
    int m;
    m = T_CS;
    if (T_SEL > m) m = T_SEL;
    if (T_DAT > m) m = T_DAT;
    if (m <= exp_pulse()) m = exp_pulse() + 1;
    return m - exp_pulse();
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // phase: 0 idle, 1 setup, 2 strobe, 3 hold, 4 between words
  task automatic expect_phase(input int k, input bit pair, output int ph, output bit second);
    int seg, j;
    seg = exp_lead() + exp_pulse() + exp_hold();
    second = 1'b0;
    j = k;
    if (pair && k > seg) begin
      second = 1'b1;
      if (k == seg + 1) begin ph = 4; return; end
      j = k - seg - 1;
    end
    if (j <= exp_lead())                        ph = 1;
    else if (j <= exp_lead() + exp_pulse())     ph = 2;
    else if (j <= seg)                          ph = 3;
    else                                        ph = 0;
  endtask

  task automatic run_txn(input bit chan, input bit pair, input logic [DW-1:0] d0,
                         input logic [DW-1:0] d1, input bit poke);
    int total, ph, bad_setup, bad_pulse, bad_cs, bad_bus, bad_rdy, v0;
    bit second, exp_sel;
    logic [DW-1:0] exp_db;
    total = exp_lead() + exp_pulse() + exp_hold();
    if (pair) total = 2 * total + 1;
    bad_setup = 0; bad_pulse = 0; bad_cs = 0; bad_bus = 0; bad_rdy = 0;
    v0 = violations;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = chan; req_pair = pair;
    req_data = d0; req_data_b = d1;
    for (int k = 1; k <= total + 1; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (poke && k == 2) begin
        req_valid = 1'b1; req_chan = ~chan; req_pair = 1'b0; req_data = ~d0;
      end
      if (poke && k == 3) req_valid = 1'b0;
      expect_phase(k, pair, ph, second);
      exp_sel = pair ? second : chan;
      exp_db  = second ? d1 : d0;
      if (req_ready !== (ph == 0)) bad_rdy++;
      if (dac_cs_n !== (ph == 0)) bad_cs++;
      if (dac_wr_n !== (ph != 2)) begin
        if (ph == 1) bad_setup++; else bad_pulse++;
      end
      if (ph != 0 && (dac_sel !== exp_sel || dac_db !== exp_db)) bad_bus++;
    end
    check(bad_setup == 0, "R6 lead before strobe", bad_setup, 0);
    check(bad_pulse == 0, "R5 strobe width", bad_pulse, 0);
    check(bad_cs == 0, "R7 chip select span", bad_cs, 0);
    check(bad_rdy == 0, "R10 ready timing", bad_rdy, 0);
    check(bad_bus == 0, pair ? "R9 pair order" : "R4 bus held", bad_bus, 0);
    check(violations == v0, "R4 change while latch open", violations - v0, 0);
    if (pair) begin sb_a = d0; sb_b = d1; end
    else if (chan) sb_b = d0;
    else sb_a = d0;
    check(lat_a === sb_a, poke ? "R2 ignored request A" : "R8 channel A", lat_a, sb_a);
    check(lat_b === sb_b, poke ? "R2 ignored request B" : "R8 channel B", lat_b, sb_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(dac_cs_n === 1'b1 && dac_wr_n === 1'b1, "R1 strobes in reset",
          {dac_cs_n, dac_wr_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && dac_cs_n === 1'b1 && dac_wr_n === 1'b1,
          "R1 idle after reset", {req_ready, dac_cs_n, dac_wr_n}, 3'b111);
    // Directed corners
    run_txn(1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    run_txn(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    run_txn(1'b0, 1'b0, 8'hA5, 8'h00, 1'b1);
    run_txn(1'b1, 1'b1, 8'h3C, 8'hC3, 1'b0);
    run_txn(1'b0, 1'b1, 8'h80, 8'h7F, 1'b1);
    run_txn(1'b0, 1'b0, 8'h80, 8'h00, 1'b0);
    // Random mix
    for (int n = 0; n < 40; n++) begin
      run_txn(1'($urandom % 2), ($urandom % 4) == 0, 8'($urandom), 8'($urandom),
              ($urandom % 5) == 0);
    end
    check(violations == 0, "R4 total latch violations", violations, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule